// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block predicts the direction of conditional "branch if not equal" instructions in a short in-order pipeline. It holds one 2-bit saturating confidence counter for each instruction word slot, selected by the word address of the branch. A combinational lookup port serves the decode stage: it returns a taken prediction for the branch sitting there. An update port serves the execute stage once the branch has resolved: it receives the predicted and the actual direction and retrains the counter.

The block also produces the pipeline steering controls. A branch predicted taken in decode clears the fetch/decode register and sends fetch to the decode-computed target. A branch resolved in execute against its prediction clears both the fetch/decode and decode/execute registers and sends fetch to the correct path. The two candidate addresses of that path come in as inputs. A misprediction in execute wins over a decode redirect in the same cycle, because it belongs to the older instruction.

Top module: `bpred_2bit`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken). Counter codes: 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken.
- R2: The counter is selected by PC bits [5:2] (PC divided by 4, modulo 16). PC bits [1:0] and bits above 5 have no effect on the selection.
- R3: `id_pred_taken` is 1 exactly when `id_is_br` is 1 and the selected counter holds 2 or 3.
- R4: A decode-stage branch predicted taken, with no execute misprediction, raises `flush_ifid` and `redirect_valid`, sets `redirect_pc` to `id_target` and leaves `flush_idex` low.
- R5: A resolved branch whose outcome equals `ex_pred_taken` sets its counter to 3 if taken and to 0 if not taken.
- R6: A resolved branch whose outcome differs from `ex_pred_taken` moves its counter one step: up when taken, down when not taken.
- R7: A misprediction raises `flush_ifid`, `flush_idex` and `redirect_valid` in the same cycle, with `redirect_pc` equal to `ex_target` when taken and to `ex_pc_plus4` when not taken; this wins over any decode redirect.
- R8: When an update and a lookup select the same counter in one cycle, the lookup returns the value held before the update; the new value is seen by lookups from the next cycle.
- R9: With `id_is_br` low the block makes no prediction, flush or redirect from decode; with `ex_is_br` low no counter changes.
- R10: A one-step move never leaves the range 0..3: stepping up from 3 keeps 3, stepping down from 0 keeps 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| id_is_br | input | 1 | Decode stage holds a conditional branch |
| id_pc | input | ADDR_W | Address of the decode-stage instruction |
| id_target | input | ADDR_W | Branch target computed in decode |
| id_pred_taken | output | 1 | Taken prediction for the decode-stage branch |
| ex_is_br | input | 1 | Execute stage holds a resolved conditional branch |
| ex_pc | input | ADDR_W | Address of the execute-stage branch |
| ex_pred_taken | input | 1 | Direction that was predicted for that branch |
| ex_taken | input | 1 | Resolved direction of that branch |
| ex_target | input | ADDR_W | Branch target of the execute-stage branch |
| ex_pc_plus4 | input | ADDR_W | Fall-through address of the execute-stage branch |
| flush_ifid | output | 1 | Clear the fetch/decode pipeline register |
| flush_idex | output | 1 | Clear the decode/execute pipeline register |
| redirect_valid | output | 1 | Load the fetch PC with `redirect_pc` |
| redirect_pc | output | ADDR_W | Next fetch address when redirecting, zero otherwise |

## Verification
Prediction, flush and redirect outputs are combinational from the inputs and the counters, so they are due in the same cycle as the stimulus; a counter change from the update port is due one rising edge later and becomes visible through the lookup port on the following cycle. The bench drives each cycle's inputs at the falling edge and compares all outputs a nanosecond later against a behavioural counter array that still holds the pre-edge values, then applies the update to that array at the rising edge. Same-slot update/lookup collisions, address aliasing, saturation and the execute-over-decode priority are aimed at directly, followed by a long stretch of random traffic over a few colliding slots.

// File: rtl/bpb_pkg.sv
package bpb_pkg;

  typedef enum logic [1:0] {
    CNT_SNT = 2'd0,
    CNT_WNT = 2'd1,
    CNT_WT  = 2'd2,
    CNT_ST  = 2'd3
  } cnt_t;

  // Retraining rule: agreement jumps to the strong state of the outcome,
  // disagreement walks one step toward the outcome, clamped at the ends.
  function automatic cnt_t cnt_next(cnt_t cur, logic pred, logic taken);
    cnt_t nxt;
    if (pred == taken) begin
      nxt = taken ? CNT_ST : CNT_SNT;
    end else if (taken) begin
      nxt = (cur == CNT_ST) ? CNT_ST : cnt_t'(cur + 2'd1);
    end else begin
      nxt = (cur == CNT_SNT) ? CNT_SNT : cnt_t'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic logic cnt_says_taken(cnt_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bpb_rst_sync.sv
module bpb_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/bpb_table.sv
module bpb_table
  import bpb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output cnt_t             rd_cnt,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_pred,
  input  logic             upd_taken
);

  logic [ENTRIES-1:0][1:0] cnt_q;
  logic [ENTRIES-1:0][1:0] cnt_d;
  logic [ENTRIES-1:0]      ent_we;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign ent_we[g] = upd_en && (upd_idx == IDX_W'(g));
    assign cnt_d[g]  = cnt_next(cnt_t'(cnt_q[g]), upd_pred, upd_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CNT_WNT;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ent_we[i]) cnt_q[i] <= cnt_d[i];
      end
    end
  end

  // Read sees the registered value: an update in the same cycle lands later.
  assign rd_cnt = cnt_t'(cnt_q[rd_idx]);

  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(cnt_q)); // R9

  AST_STRONG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && (upd_pred == upd_taken)
    |=> cnt_q[$past(upd_idx)] == ($past(upd_taken) ? 2'd3 : 2'd0)); // R5

  AST_STEP_UP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !upd_pred && upd_taken && (cnt_q[upd_idx] != 2'd3)
    |=> cnt_q[$past(upd_idx)] == $past(cnt_q[upd_idx]) + 2'd1); // R6

  AST_STEP_DN_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_pred && !upd_taken && (cnt_q[upd_idx] != 2'd0)
    |=> cnt_q[$past(upd_idx)] == $past(cnt_q[upd_idx]) - 2'd1); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_taken && (cnt_q[upd_idx] == 2'd3)
    |=> cnt_q[$past(upd_idx)] == 2'd3); // R10

endmodule

// File: rtl/bpb_steer.sv
module bpb_steer #(
  parameter int ADDR_W = 32
) (
  input  logic              id_hit,
  input  logic [ADDR_W-1:0] id_target,
  input  logic              ex_miss,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  input  logic [ADDR_W-1:0] ex_pc_plus4,
  output logic              flush_ifid,
  output logic              flush_idex,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_pc
);

  always_comb begin
    flush_ifid  = 1'b0;
    flush_idex  = 1'b0;
    redir_valid = 1'b0;
    redir_pc    = '0;
    if (ex_miss) begin
      flush_ifid  = 1'b1;
      flush_idex  = 1'b1;
      redir_valid = 1'b1;
      redir_pc    = ex_taken ? ex_target : ex_pc_plus4;
    end else if (id_hit) begin
      flush_ifid  = 1'b1;
      redir_valid = 1'b1;
      redir_pc    = id_target;
    end
  end

endmodule

// File: rtl/bpred_2bit.sv
module bpred_2bit
  import bpb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_is_br,
  input  logic [ADDR_W-1:0] id_pc,
  input  logic [ADDR_W-1:0] id_target,
  output logic              id_pred_taken,
  input  logic              ex_is_br,
  input  logic [ADDR_W-1:0] ex_pc,
  input  logic              ex_pred_taken,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  input  logic [ADDR_W-1:0] ex_pc_plus4,
  output logic              flush_ifid,
  output logic              flush_idex,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic             srst_n;
  logic [IDX_W-1:0] id_idx;
  logic [IDX_W-1:0] ex_idx;
  cnt_t             id_cnt;
  logic             ex_miss;

  bpb_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (srst_n)
  );

  // Word address selects the slot; byte offset bits drop out.
  assign id_idx = IDX_W'(id_pc >> 2);
  assign ex_idx = IDX_W'(ex_pc >> 2);

  bpb_table #(.ENTRIES(ENTRIES)) u_table (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_idx    (id_idx),
    .rd_cnt    (id_cnt),
    .upd_en    (ex_is_br),
    .upd_idx   (ex_idx),
    .upd_pred  (ex_pred_taken),
    .upd_taken (ex_taken)
  );

  assign id_pred_taken = id_is_br && cnt_says_taken(id_cnt);
  assign ex_miss       = ex_is_br && (ex_pred_taken != ex_taken);

  bpb_steer #(.ADDR_W(ADDR_W)) u_steer (
    .id_hit      (id_pred_taken),
    .id_target   (id_target),
    .ex_miss     (ex_miss),
    .ex_taken    (ex_taken),
    .ex_target   (ex_target),
    .ex_pc_plus4 (ex_pc_plus4),
    .flush_ifid  (flush_ifid),
    .flush_idex  (flush_idex),
    .redir_valid (redirect_valid),
    .redir_pc    (redirect_pc)
  );

  AST_NONBR_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    !id_is_br && !ex_is_br |-> !redirect_valid && !flush_ifid && !flush_idex); // R9

  AST_MISS_FLUSH_BOTH: assert property (@(posedge clk) disable iff (!srst_n)
    ex_is_br && (ex_pred_taken != ex_taken)
    |-> flush_ifid && flush_idex && redirect_valid); // R7

  AST_IDEX_NEEDS_EX: assert property (@(posedge clk) disable iff (!srst_n)
    flush_idex |-> ex_is_br); // R4

endmodule

// File: tb/tb_bpred_2bit.sv
`timescale 1ns/1ps
module tb_bpred_2bit;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          id_is_br = 1'b0;
  logic [AW-1:0] id_pc = '0;
  logic [AW-1:0] id_target = '0;
  logic          id_pred_taken;
  logic          ex_is_br = 1'b0;
  logic [AW-1:0] ex_pc = '0;
  logic          ex_pred_taken = 1'b0;
  logic          ex_taken = 1'b0;
  logic [AW-1:0] ex_target = '0;
  logic [AW-1:0] ex_pc_plus4 = '0;
  logic          flush_ifid;
  logic          flush_idex;
  logic          redirect_valid;
  logic [AW-1:0] redirect_pc;

  always #2 clk = ~clk;

  bpred_2bit dut (
    .clk(clk), .rst_n(rst_n),
    .id_is_br(id_is_br), .id_pc(id_pc), .id_target(id_target),
    .id_pred_taken(id_pred_taken),
    .ex_is_br(ex_is_br), .ex_pc(ex_pc), .ex_pred_taken(ex_pred_taken),
    .ex_taken(ex_taken), .ex_target(ex_target), .ex_pc_plus4(ex_pc_plus4),
    .flush_ifid(flush_ifid), .flush_idex(flush_idex),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  int model [16];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req,
                      input logic ib, input logic [AW-1:0] ipc, input logic [AW-1:0] itg,
                      input logic eb, input logic [AW-1:0] epc, input logic ep, input logic et,
                      input logic [AW-1:0] etg, input logic [AW-1:0] ep4);
    int  ii, ei;
    bit  e_pred, e_miss;
    logic [AW-1:0] e_pc;
    id_is_br = ib; id_pc = ipc; id_target = itg;
    ex_is_br = eb; ex_pc = epc; ex_pred_taken = ep; ex_taken = et;
    ex_target = etg; ex_pc_plus4 = ep4;
    #1;
    ii = int'((ipc / 4) % 16);
    ei = int'((epc / 4) % 16);
    e_pred = ib && (model[ii] >= 2);
    e_miss = eb && (ep != et);
    e_pc = e_miss ? (et ? etg : ep4) : (e_pred ? itg : '0);
    chk(req, "id_pred_taken", AW'(id_pred_taken), AW'(e_pred));
    chk(req, "flush_ifid", AW'(flush_ifid), AW'(e_miss || e_pred));
    chk(req, "flush_idex", AW'(flush_idex), AW'(e_miss));
    chk(req, "redirect_valid", AW'(redirect_valid), AW'(e_miss || e_pred));
    chk(req, "redirect_pc", redirect_pc, e_pc);
    @(posedge clk);
    if (eb) begin
      if (ep == et) model[ei] = et ? 3 : 0;
      else if (et)  model[ei] = (model[ei] == 3) ? 3 : model[ei] + 1;
      else          model[ei] = (model[ei] == 0) ? 0 : model[ei] - 1;
    end
    @(negedge clk);
  endtask

  // Shorthands: pure lookup, pure update.
  task automatic look(input string req, input logic [AW-1:0] pc);
    step(req, 1'b1, pc, pc + 32'h100, 1'b0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic upd(input string req, input logic [AW-1:0] pc, input logic p, input logic t);
    step(req, 1'b0, '0, '0, 1'b1, pc, p, t, pc + 32'h200, pc + 32'd4);
  endtask

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R3: all slots predict not taken after reset
    for (int i = 0; i < 16; i++) look("R1", 32'(i * 4));
    // R9: no branch anywhere -> quiet
    step("R9", 1'b0, 32'h8, 32'h44, 1'b0, 32'h8, 1'b1, 1'b0, 32'h50, 32'hC);

    // R6 R7: weak NT -> taken miss -> 2, redirect to target, both flushes
    upd("R7", 32'h0C, 1'b0, 1'b1);
    // R4 R3: slot 3 now predicts taken
    look("R4", 32'h0C);
    // R5: correct taken -> 3
    upd("R5", 32'h0C, 1'b1, 1'b1);
    // R6: taken-predicted not-taken -> 2, still taken; then -> 1
    upd("R6", 32'h0C, 1'b1, 1'b0);
    look("R6", 32'h0C);
    upd("R6", 32'h0C, 1'b1, 1'b0);
    look("R6", 32'h0C);

    // R5: correct not-taken -> 0; a miss then only reaches 1
    upd("R5", 32'h14, 1'b0, 1'b0);
    upd("R6", 32'h14, 1'b0, 1'b1);
    look("R5", 32'h14);

    // R8: same-slot update and lookup, lookup sees old value
    step("R8", 1'b1, 32'h1C, 32'h300, 1'b1, 32'h1C, 1'b0, 1'b1, 32'h400, 32'h20);
    look("R8", 32'h1C);

    // R2: aliases of slot 7 (low byte bits, high bits)
    look("R2", 32'h1F);
    look("R2", 32'h5C);
    look("R2", 32'hFFFF_FF1D);
    upd("R2", 32'h4000_0018, 1'b0, 1'b1);
    look("R2", 32'h18);

    // R9: slot 7 taken but not a branch in ID; ex fields set but not valid
    step("R9", 1'b0, 32'h1C, 32'h300, 1'b0, 32'h1C, 1'b1, 1'b0, 32'h10, 32'h20);
    look("R9", 32'h1C);

    // R7: EX miss wins over ID predicted-taken redirect
    upd("R5", 32'h0C, 1'b1, 1'b1);
    step("R7", 1'b1, 32'h0C, 32'h300, 1'b1, 32'h24, 1'b1, 1'b0, 32'h500, 32'h28);
    step("R7", 1'b1, 32'h0C, 32'h300, 1'b1, 32'h24, 1'b0, 1'b1, 32'h500, 32'h28);

    // R10: clamping at both ends with inconsistent predicted bits
    upd("R10", 32'h24, 1'b1, 1'b1);
    upd("R10", 32'h24, 1'b0, 1'b1);
    look("R10", 32'h24);
    upd("R10", 32'h24, 1'b0, 1'b0);
    upd("R10", 32'h24, 1'b1, 1'b0);
    upd("R10", 32'h24, 1'b0, 1'b1);
    look("R10", 32'h24);

    // R3 R5 R6 R8: random traffic on four colliding slots
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] ipc, epc;
      logic ep, et;
      ipc = 32'(($urandom % 4) * 4 + ($urandom % 4)) | (32'($urandom % 8) << 6);
      epc = 32'(($urandom % 4) * 4);
      et  = 1'($urandom);
      ep  = (model[int'((epc / 4) % 16)] >= 2);
      if (($urandom % 4) == 0) ep = ~ep;
      step("R3", 1'($urandom), ipc, 32'($urandom), 1'($urandom), epc, ep, et,
           32'($urandom), epc + 32'd4);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule